// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block runs single accesses on an 8080-style parallel display bus. A register front end hands it one request at a time: a command write, a parameter write or a read. The block then produces the active-low chip-select, write-strobe and read-strobe waveforms on a tick grid, drives the data bus during writes, and captures the panel's data at a programmed tick during reads. Two packed timing words place every strobe edge independently; one select bit sets the tick to one or two clock periods.

The controller is a three-state machine. `ST_IDLE` waits for a request, and the transition *accept* (request valid while idle) loads the request and clears the tick count. `ST_STROBE` counts ticks while the strobes follow their windows. The transition *cycle_end* (last tick of the access length) leads to `ST_GAP`, or straight back to `ST_IDLE` when the recovery width is zero (*cycle_end_nogap*). `ST_GAP` holds every strobe inactive for the chip-select recovery width. The transition *gap_end* returns to `ST_IDLE` and emits `done`. The requester holds its request until `busy` is low, which gives back-to-back stalling with no buffer.

Timing words that break the ordering rules are repaired rather than followed, so an off edge never comes before its on edge and an access is never shorter than its strobes.

Top module: `pbus_strobe_timer`

## Requirements
- R1: During and after reset, `bus_cs_n`, `bus_we_n` and `bus_re_n` are high, and `busy`, `done` and `bus_oe` are low.
- R2: `cfg_edges` packs chip-select on/off in bits 3:0/9:4, write-strobe on/off in bits 13:10/19:14 and read-strobe on/off in bits 23:20/29:24. With the tick count starting at 0 on accept, each strobe is low while the count is at least its on value and below its off value.
- R3: `cfg_cycles` packs the write cycle length in bits 5:0, the read cycle length in bits 11:6, the chip-select recovery width in bits 17:12 and the read access tick in bits 27:22. A write access lasts max(write cycle, effective write-off, effective CS-off) ticks. A read access lasts max(read cycle, effective read-off, effective CS-off, effective access tick + 1) ticks.
- R4: With `cfg_div2` = 0 one tick is one clock; with `cfg_div2` = 1 one tick is two clocks, so every duration and edge position doubles.
- R5: Clamping: an off value not above its on value is taken as on + 1. The effective CS-off is the largest of the CS-off field, CS-on + 1, the effective write-off and the effective read-off.
- R6: A read captures `bus_din` into `rd_data` in the first clock of tick max(access field, read-on + 1). `rd_data` keeps that value through later write accesses.
- R7: `req_kind` 0 is a command write (`bus_dc` = 0), 1 is a parameter write (`bus_dc` = 1) and 2 is a read (`bus_dc` = 1). During a write access `bus_oe` is high and `bus_dout` carries `req_data`. The write strobe never pulses on a read and the read strobe never pulses on a write.
- R8: `busy` is high from the clock after accept until the access and its recovery gap end. A request held while busy is not taken, and it does not disturb the running access. `done` pulses for exactly the first idle clock after each access.
- R9: After the access length, all strobes stay high for recovery-width ticks while `busy` stays high. A width of 0 ends the access immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_edges | input | 32 | Packed strobe on/off ticks |
| cfg_cycles | input | 32 | Packed cycle lengths, recovery width, access tick |
| cfg_div2 | input | 1 | Tick is two clocks when high |
| req_valid | input | 1 | Request pending; held until accepted |
| req_kind | input | 2 | 0 command, 1 parameter, 2 read |
| req_data | input | DATA_W | Write data |
| busy | output | 1 | Access or recovery in progress |
| done | output | 1 | One-clock pulse at access end |
| rd_data | output | DATA_W | Last captured read value |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Data/command select |
| bus_dout | output | DATA_W | Bus write data |
| bus_oe | output | 1 | Bus output enable |
| bus_din | input | DATA_W | Bus read data |

## Verification
On every cycle the assertions check these properties: strobes stay high while idle and during the recovery gap; the two data strobes never overlap; a low write strobe always comes with the bus driven and the data steady; `done` only follows a busy period; the tick count stays inside the access length; and the halved tick alternates. Edge placement, access and gap lengths, the clamping arithmetic, the sampling tick of a read, and stalling of a second request can only be shown by the bench's scenarios. The bench records where each strobe falls and rises in each access and compares this against a model of the field rules. The panel data changes every clock, so a capture one tick off shows up as a wrong value.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int WORD_W = 32;
    localparam int ON_W   = 4;
    localparam int OFF_W  = 6;
    localparam int CNT_W  = OFF_W + 1;

    localparam logic [1:0] KIND_CMD   = 2'd0;
    localparam logic [1:0] KIND_PARAM = 2'd1;
    localparam logic [1:0] KIND_READ  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2
    } fsm_e;

    typedef struct packed {
        logic [CNT_W-1:0] cs_on;
        logic [CNT_W-1:0] cs_off;
        logic [CNT_W-1:0] we_on;
        logic [CNT_W-1:0] we_off;
        logic [CNT_W-1:0] re_on;
        logic [CNT_W-1:0] re_off;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] wr_len;
        logic [CNT_W-1:0] rd_len;
        logic [CNT_W-1:0] gap;
    } tim_t;
endpackage

// File: rtl/pbus_timing_clamp.sv
module pbus_timing_clamp
    import pbus_pkg::*;
(
    input  logic [WORD_W-1:0] edges,
    input  logic [WORD_W-1:0] cycles,
    output tim_t              tim
);
    function automatic logic [CNT_W-1:0] max2(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic unused_bits;
    assign unused_bits = ^{edges[31:30], cycles[31:28], cycles[21:18]};

    logic [CNT_W-1:0] we_off_e, re_off_e, cs_off_e, acc_e;

    always_comb begin
        tim.cs_on  = CNT_W'(edges[3:0]);
        tim.we_on  = CNT_W'(edges[13:10]);
        tim.re_on  = CNT_W'(edges[23:20]);
        we_off_e   = max2(CNT_W'(edges[19:14]), tim.we_on + ONE);
        re_off_e   = max2(CNT_W'(edges[29:24]), tim.re_on + ONE);
        cs_off_e   = max2(max2(CNT_W'(edges[9:4]), tim.cs_on + ONE),
                          max2(we_off_e, re_off_e));
        acc_e      = max2(CNT_W'(cycles[27:22]), tim.re_on + ONE);
        tim.we_off = we_off_e;
        tim.re_off = re_off_e;
        tim.cs_off = cs_off_e;
        tim.acc    = acc_e;
        tim.wr_len = max2(max2(CNT_W'(cycles[5:0]), we_off_e), cs_off_e);
        tim.rd_len = max2(max2(CNT_W'(cycles[11:6]), re_off_e),
                          max2(cs_off_e, acc_e + ONE));
        tim.gap    = CNT_W'(cycles[17:12]);
    end
endmodule

// File: rtl/pbus_tick_gen.sv
module pbus_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div2,
    output logic tick,
    output logic first
);
    logic phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase <= 1'b0;
        else if (run && div2)  phase <= ~phase;
        else                   phase <= 1'b0;
    end

    assign tick  = run && (!div2 || phase);
    assign first = !phase;

    // R4: a halved tick never fires on two clocks in a row
    p_tick_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div2 && tick) |=> (!tick || !div2));
endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
    import pbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_edges,
    input  logic [31:0]       cfg_cycles,
    input  logic              cfg_div2,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_cs_n,
    output logic              bus_we_n,
    output logic              bus_re_n,
    output logic              bus_dc,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_din
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tim_t             tim;
    fsm_e             state, st_n;
    logic [CNT_W-1:0] cnt, cnt_n, len_cur;
    logic             is_rd_q, is_rd_n, dc_q, dc_n;
    logic [DATA_W-1:0] data_q;
    logic             tick, first, accept;
    logic             cs_q, we_q, re_q, oe_q, done_q;
    logic [DATA_W-1:0] rd_q;

    pbus_timing_clamp u_clamp (
        .edges  (cfg_edges),
        .cycles (cfg_cycles),
        .tim    (tim)
    );

    pbus_tick_gen u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .div2  (cfg_div2),
        .tick  (tick),
        .first (first)
    );

    assign accept  = (state == ST_IDLE) && req_valid;
    assign len_cur = is_rd_q ? tim.rd_len : tim.wr_len;
    assign is_rd_n = accept ? (req_kind == KIND_READ) : is_rd_q;
    assign dc_n    = accept ? (req_kind != KIND_CMD) : dc_q;

    // next-state logic
    always_comb begin
        st_n  = state;
        cnt_n = cnt;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    st_n  = ST_STROBE;
                    cnt_n = '0;
                end
            end
            ST_STROBE: begin
                if (tick) begin
                    if (cnt == len_cur - ONE) begin
                        cnt_n = '0;
                        st_n  = (tim.gap == '0) ? ST_IDLE : ST_GAP;
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (cnt == tim.gap - ONE) begin
                        cnt_n = '0;
                        st_n  = ST_IDLE;
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            is_rd_q <= 1'b0;
            dc_q    <= 1'b1;
            data_q  <= '0;
        end else begin
            state   <= st_n;
            cnt     <= cnt_n;
            is_rd_q <= is_rd_n;
            dc_q    <= dc_n;
            if (accept) data_q <= req_data;
        end
    end

    // registered outputs, decoded from the next state so they are glitch free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            we_q   <= 1'b0;
            re_q   <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
            rd_q   <= '0;
        end else begin
            cs_q   <= (st_n == ST_STROBE) && (cnt_n >= tim.cs_on) && (cnt_n < tim.cs_off);
            we_q   <= (st_n == ST_STROBE) && !is_rd_n &&
                      (cnt_n >= tim.we_on) && (cnt_n < tim.we_off);
            re_q   <= (st_n == ST_STROBE) && is_rd_n &&
                      (cnt_n >= tim.re_on) && (cnt_n < tim.re_off);
            oe_q   <= (st_n == ST_STROBE) && !is_rd_n;
            done_q <= (state != ST_IDLE) && (st_n == ST_IDLE);
            if ((state == ST_STROBE) && is_rd_q && first && (cnt == tim.acc))
                rd_q <= bus_din;
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign rd_data  = rd_q;
    assign bus_cs_n = !cs_q;
    assign bus_we_n = !we_q;
    assign bus_re_n = !re_q;
    assign bus_dc   = dc_q;
    assign bus_oe   = oe_q;
    assign bus_dout = oe_q ? data_q : '0;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_cs_n && bus_we_n && bus_re_n && !bus_oe));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_re_n));

    p_we_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_oe);

    p_dout_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n && $past(!bus_we_n)) |-> $stable(bus_dout));

    p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE) |-> (cnt < len_cur));

    p_gap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (bus_cs_n && bus_we_n && bus_re_n && busy));
endmodule

// File: tb/pbus_strobe_timer_tb.sv
module pbus_strobe_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_edges = '0, cfg_cycles = '0;
    logic        cfg_div2 = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_data = '0;
    logic        busy, done, bus_cs_n, bus_we_n, bus_re_n, bus_dc, bus_oe;
    logic [7:0]  rd_data, bus_dout;
    logic [7:0]  bus_din = '0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pbus_strobe_timer #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_edges(cfg_edges), .cfg_cycles(cfg_cycles),
        .cfg_div2(cfg_div2), .req_valid(req_valid), .req_kind(req_kind),
        .req_data(req_data), .busy(busy), .done(done), .rd_data(rd_data),
        .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_re_n(bus_re_n),
        .bus_dc(bus_dc), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
    );

    typedef struct {
        logic [7:0] data;
        logic [7:0] seed;
        logic       dc;
        int csf, csl, wef, wel, rf, rl, blen;
        logic [7:0] rd;
        string tag;
    } item_t;

    item_t sb[$];

    // timing model state
    int m_cson, m_csoff, m_weon, m_weoff, m_reon, m_reoff;
    int m_wecyc, m_recyc, m_gap, m_acc, m_div;
    logic [7:0] last_rd = '0;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_timing(input int cson, csoff, weon, weoff, reon, reoff,
                              input int wecyc, recyc, gap, acc, input bit div2);
        m_cson = cson; m_csoff = csoff; m_weon = weon; m_weoff = weoff;
        m_reon = reon; m_reoff = reoff; m_wecyc = wecyc; m_recyc = recyc;
        m_gap = gap; m_acc = acc; m_div = div2 ? 2 : 1;
        cfg_edges  = {2'b00, 6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)};
        cfg_cycles = {4'b0000, 6'(acc), 4'b0000, 6'(gap), 6'(recyc), 6'(wecyc)};
        cfg_div2   = div2;
    endtask

    task automatic issue(input int kind, input logic [7:0] data,
                         input logic [7:0] seed, input string tag);
        item_t it;
        int weoff_e, reoff_e, csoff_e, acc_e, len;
        bit rd;
        rd      = (kind == 2);
        weoff_e = imax(m_weoff, m_weon + 1);
        reoff_e = imax(m_reoff, m_reon + 1);
        csoff_e = imax(imax(m_csoff, m_cson + 1), imax(weoff_e, reoff_e));
        acc_e   = imax(m_acc, m_reon + 1);
        len     = rd ? imax(imax(m_recyc, reoff_e), imax(csoff_e, acc_e + 1))
                     : imax(imax(m_wecyc, weoff_e), csoff_e);
        it.data = data;
        it.seed = seed;
        it.dc   = (kind != 0);
        it.tag  = tag;
        it.csf  = m_cson * m_div;
        it.csl  = (csoff_e - m_cson) * m_div;
        it.wef  = rd ? -1 : m_weon * m_div;
        it.wel  = rd ? 0 : (weoff_e - m_weon) * m_div;
        it.rf   = rd ? m_reon * m_div : -1;
        it.rl   = rd ? (reoff_e - m_reon) * m_div : 0;
        it.blen = (len + m_gap) * m_div;
        it.rd   = rd ? (seed ^ 8'(acc_e * m_div)) : last_rd;
        last_rd = it.rd;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_data  = data;
        while (busy) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_data  = ~data;
    endtask

    // monitor / scoreboard
    bit    in_acc = 0;
    int    idx, o_csf, o_csl, o_wef, o_wel, o_rf, o_rl, dmis;
    item_t cur;

    always @(negedge clk) begin
        if (!rst_n) begin
            in_acc = 0;
        end else if (busy) begin
            if (!in_acc) begin
                in_acc = 1; idx = 0; dmis = 0;
                o_csf = -1; o_csl = 0; o_wef = -1; o_wel = 0; o_rf = -1; o_rl = 0;
                if (sb.size() == 0) begin
                    chk(0, "R8", "unexpected access start", 1, 0);
                    cur.data = '0; cur.seed = '0; cur.dc = 1'b1; cur.tag = "R8";
                end else begin
                    cur = sb.pop_front();
                end
            end else begin
                idx++;
            end
            if (!bus_cs_n) begin if (o_csf < 0) o_csf = idx; o_csl++; end
            if (!bus_we_n) begin if (o_wef < 0) o_wef = idx; o_wel++; end
            if (!bus_re_n) begin if (o_rf < 0) o_rf = idx; o_rl++; end
            if (!bus_we_n && (!bus_oe || bus_dout != cur.data || bus_dc != cur.dc)) dmis++;
            if (!bus_re_n && bus_dc != 1'b1) dmis++;
            bus_din = cur.seed ^ 8'(idx);
        end else if (in_acc) begin
            in_acc = 0;
            chk(o_csf == cur.csf, cur.tag, "R2 cs first low clock", o_csf, cur.csf);
            chk(o_csl == cur.csl, cur.tag, "R2 R5 cs low clocks", o_csl, cur.csl);
            chk(o_wef == cur.wef, cur.tag, "R2 R7 we first low clock", o_wef, cur.wef);
            chk(o_wel == cur.wel, cur.tag, "R5 R7 we low clocks", o_wel, cur.wel);
            chk(o_rf == cur.rf, cur.tag, "R2 R7 re first low clock", o_rf, cur.rf);
            chk(o_rl == cur.rl, cur.tag, "R5 R7 re low clocks", o_rl, cur.rl);
            chk(idx + 1 == cur.blen, cur.tag, "R3 R9 busy clocks", idx + 1, cur.blen);
            chk(dmis == 0, cur.tag, "R7 R8 bus data/dc mismatches", dmis, 0);
            chk(done == 1'b1, cur.tag, "R8 done at access end", int'(done), 1);
            chk(rd_data == cur.rd, cur.tag, "R6 rd_data", int'(rd_data), int'(cur.rd));
        end else begin
            if (done) chk(0, "R8", "done without access", 1, 0);
        end
    end

    task automatic wait_idle();
        while (sb.size() != 0 || busy || in_acc) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(bus_cs_n && bus_we_n && bus_re_n, "R1", "strobes high in reset",
            int'({bus_cs_n, bus_we_n, bus_re_n}), 7);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !bus_oe, "R1", "busy/done/oe low after reset",
            int'({busy, done, bus_oe}), 0);
        chk(bus_cs_n && bus_we_n && bus_re_n, "R1", "strobes high after reset",
            int'({bus_cs_n, bus_we_n, bus_re_n}), 7);

        // R2 R3 R7: legal timing, one-clock tick; command then parameter back to back (R8 stall)
        set_timing(1, 8, 2, 5, 1, 6, 10, 12, 2, 4, 1'b0);
        issue(0, 8'h3C, 8'h00, "R2");
        issue(1, 8'hA5, 8'h00, "R8");
        issue(2, 8'h00, 8'h5A, "R6");
        issue(1, 8'h77, 8'h00, "R6");
        wait_idle();

        // R4: two-clock tick, same fields
        set_timing(1, 8, 2, 5, 1, 6, 10, 12, 2, 4, 1'b1);
        issue(1, 8'hC3, 8'h00, "R4");
        issue(2, 8'h00, 8'h96, "R4");
        wait_idle();

        // R5: broken ordering, zero cycle fields, zero recovery gap (R9)
        set_timing(3, 2, 5, 5, 4, 1, 0, 0, 0, 2, 1'b0);
        issue(0, 8'h12, 8'h00, "R5");
        issue(2, 8'h00, 8'hE1, "R5");
        issue(1, 8'h34, 8'h00, "R9");
        wait_idle();

        // R3 R6: widest fields, access tick at the top, halved tick
        set_timing(15, 63, 15, 63, 15, 63, 63, 63, 1, 63, 1'b1);
        issue(2, 8'h00, 8'h0F, "R3");
        issue(0, 8'hF0, 8'h00, "R3");
        wait_idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule